// File: doc/BRIEF.md
# Floating-Point Reciprocal Exponent Estimator

This block produces a coarse scale factor for one floating-point operand, which is used ahead of a reciprocal refinement loop. The operand may be half (binary16), single (binary32) or double (binary64) precision. The result keeps the operand's sign and carries a new exponent field, and its fraction is zero. The new exponent is the bitwise inverse of the operand's exponent. When the operand's exponent field is zero, a fixed value is used instead. NaN operands take a separate path: they are either quieted or replaced by a canonical NaN, and a signaling NaN raises an invalid-operation flag.

Two mode inputs set how special operands are treated. Flush-to-zero treats a denormal operand as a signed zero and raises a flag to say so. Default-NaN mode replaces any NaN result with the format's canonical quiet NaN. The outputs are registered, so each result appears one clock after its operand.

Top module: `recip_exp_est`

## Requirements
- R1: For a non-NaN operand, result bit at the format's sign position equals the operand's sign bit, and every fraction bit of the result is zero.
- R2: An operand whose exponent field is all zeros (zero or subnormal) gives an exponent field of 0x1E (half), 0xFE (single) or 0x7FE (double).
- R3: An operand with a nonzero exponent field gives the bitwise complement of that field within its width. An infinity therefore gives a signed zero.
- R4: invalid_o is 1 exactly when the operand is a signaling NaN, meaning an all-ones exponent, a nonzero fraction and a clear top fraction bit. A quiet NaN leaves invalid_o at 0.
- R5: A NaN operand with dn_mode_i=0 returns the operand with its top fraction bit set. With dn_mode_i=1 it returns 0x7E00, 0x7FC00000 or 0x7FF8000000000000 for half, single and double.
- R6: With ftz_i=1, a denormal operand (zero exponent, nonzero fraction) sets flushed_o and gives the signed-zero result. With ftz_i=0, flushed_o stays 0 for every operand.
- R7: fmt_i selects the format: 0 is half (exponent bits 14:10, sign bit 15), 1 is single (30:23, sign 31), 2 is double (62:52, sign 63), and 3 behaves as double.
- R8: For half and single, operand bits above the format width are ignored, and result_o bits above the format width are zero.
- R9: Outputs update on the clock edge after the operand is presented. A synchronous active-high rst clears result_o, invalid_o and flushed_o to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| operand_i | input | 64 | Operand, right-aligned for half and single |
| fmt_i | input | 2 | Format select |
| ftz_i | input | 1 | Flush denormal operands to zero |
| dn_mode_i | input | 1 | Replace NaN results with the default NaN |
| result_o | output | 64 | Sign plus estimated exponent, or NaN |
| invalid_o | output | 1 | Signaling NaN seen |
| flushed_o | output | 1 | Denormal operand was flushed |

## Verification
Signed zeros, subnormals, normal values and infinities are run in every format. These tell the fixed zero-exponent value apart from the complement path. Signaling and quiet NaNs are run with default-NaN mode both off and on, which separates quieting, substitution and the invalid flag. Subnormals are run with flush-to-zero both on and off, and half and single operands carry junk in their upper bits to show that those bits are masked. A long stream of random operands with mixed formats and modes is compared every clock against a behavioural model, and a reset in the middle of the run checks that the outputs clear.

// File: rtl/rxe_pkg.sv
package rxe_pkg;
  localparam int XLEN   = 64;
  localparam int NFMT   = 3;
  localparam int FMT_W  = 2;
  localparam int FMT_EW [NFMT] = '{5, 8, 11};
  localparam int FMT_FW [NFMT] = '{10, 23, 52};

  typedef enum logic [FMT_W-1:0] {
    FMT_HALF   = 2'd0,
    FMT_SINGLE = 2'd1,
    FMT_DOUBLE = 2'd2,
    FMT_ALT_DB = 2'd3
  } fmt_e;

  typedef struct packed {
    logic [XLEN-1:0] value;
    logic            invalid;
    logic            flushed;
  } lane_out_t;
endpackage

// File: rtl/rxe_lane.sv
module rxe_lane #(
  parameter int EW = 8,
  parameter int FW = 23,
  localparam int W = 1 + EW + FW
) (
  input  logic [W-1:0] op_i,
  input  logic         ftz_i,
  input  logic         dn_i,
  output logic [W-1:0] res_o,
  output logic         invalid_o,
  output logic         flushed_o
);
  localparam logic [EW-1:0] EXP_ZPATH = {{(EW-1){1'b1}}, 1'b0};
  localparam logic [W-1:0]  CANON_NAN = {1'b0, {EW{1'b1}}, 1'b1, {(FW-1){1'b0}}};
  localparam logic [W-1:0]  QUIET_BIT = W'(1) << (FW - 1);

  logic          sgn;
  logic [EW-1:0] exp_in;
  logic [FW-1:0] frac_in;
  logic          exp_ones, exp_zero, frac_nz, is_nan;
  logic [EW-1:0] exp_est;

  assign sgn     = op_i[W-1];
  assign exp_in  = op_i[W-2:FW];
  assign frac_in = op_i[FW-1:0];

  assign exp_ones = &exp_in;
  assign exp_zero = ~|exp_in;
  assign frac_nz  = |frac_in;
  assign is_nan   = exp_ones & frac_nz;

  // Zero and subnormal share one path, so flushing changes only the flag.
  assign exp_est = exp_zero ? EXP_ZPATH : ~exp_in;

  assign invalid_o = is_nan & ~frac_in[FW-1];
  assign flushed_o = ftz_i & exp_zero & frac_nz;

  always_comb begin
    if (is_nan)
      res_o = dn_i ? CANON_NAN : (op_i | QUIET_BIT);
    else
      res_o = {sgn, exp_est, {FW{1'b0}}};
  end
endmodule

// File: rtl/rxe_pick.sv
module rxe_pick
  import rxe_pkg::*;
#(
  parameter int N = NFMT
) (
  input  lane_out_t            lanes_i [N],
  input  logic [FMT_W-1:0]     fmt_i,
  output lane_out_t            sel_o
);
  always_comb begin
    sel_o = lanes_i[N-1];
    for (int k = 0; k < N; k++) begin
      if (fmt_i == FMT_W'(k)) sel_o = lanes_i[k];
    end
  end
endmodule

// File: rtl/recip_exp_est.sv
module recip_exp_est
  import rxe_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [63:0]     operand_i,
  input  logic [1:0]      fmt_i,
  input  logic            ftz_i,
  input  logic            dn_mode_i,
  output logic [63:0]     result_o,
  output logic            invalid_o,
  output logic            flushed_o
);
  lane_out_t lanes [NFMT];
  lane_out_t picked;

  for (genvar g = 0; g < NFMT; g++) begin : g_lane
    localparam int LW = 1 + FMT_EW[g] + FMT_FW[g];
    logic [LW-1:0] r;
    logic          inv, fl;
    rxe_lane #(.EW(FMT_EW[g]), .FW(FMT_FW[g])) u_lane (
      .op_i      (operand_i[LW-1:0]),
      .ftz_i     (ftz_i),
      .dn_i      (dn_mode_i),
      .res_o     (r),
      .invalid_o (inv),
      .flushed_o (fl)
    );
    assign lanes[g] = '{value: XLEN'(r), invalid: inv, flushed: fl};
  end

  rxe_pick #(.N(NFMT)) u_pick (
    .lanes_i (lanes),
    .fmt_i   (fmt_i),
    .sel_o   (picked)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o  <= '0;
      invalid_o <= 1'b0;
      flushed_o <= 1'b0;
    end else begin
      result_o  <= picked.value;
      invalid_o <= picked.invalid;
      flushed_o <= picked.flushed;
    end
  end

  AST_INVALID_QUIET_OUT: assert property (@(posedge clk) disable iff (rst)
    (invalid_o && $past(fmt_i) == FMT_SINGLE) |-> (result_o[30:23] == 8'hFF && result_o[22]))
    else $error("AST_INVALID_QUIET_OUT"); // R5
  AST_FLUSH_NEEDS_FTZ: assert property (@(posedge clk) disable iff (rst)
    flushed_o |-> $past(ftz_i))
    else $error("AST_FLUSH_NEEDS_FTZ"); // R6
  AST_FLUSH_NOT_NAN: assert property (@(posedge clk) disable iff (rst)
    !(flushed_o && invalid_o))
    else $error("AST_FLUSH_NOT_NAN"); // R4
  AST_HALF_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(fmt_i) == FMT_HALF) |-> (result_o[63:16] == '0))
    else $error("AST_HALF_UPPER_ZERO"); // R8
  AST_SINGLE_FRAC_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(fmt_i) == FMT_SINGLE && result_o[30:23] != 8'hFF) |-> (result_o[22:0] == '0))
    else $error("AST_SINGLE_FRAC_ZERO"); // R1
endmodule

// File: tb/tb_recip_exp_est.sv
module tb_recip_exp_est;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] operand_i = '0;
  logic [1:0]  fmt_i = '0;
  logic        ftz_i = 1'b0;
  logic        dn_mode_i = 1'b0;
  logic [63:0] result_o;
  logic        invalid_o, flushed_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  recip_exp_est dut (.*);

  function automatic void model(input logic [63:0] op, input logic [1:0] f,
                                input logic ftz, input logic dn,
                                output logic [63:0] r, output logic inv, output logic fl);
    int ew, fw;
    logic [63:0] m, e, fr, emax, s, ne;
    case (f)
      2'd0: begin ew = 5;  fw = 10; end
      2'd1: begin ew = 8;  fw = 23; end
      default: begin ew = 11; fw = 52; end
    endcase
    m    = (64'd1 << (ew + fw + 1)) - 64'd1;
    if (ew + fw + 1 == 64) m = '1;
    op   = op & m;
    emax = (64'd1 << ew) - 64'd1;
    s    = (op >> (ew + fw)) & 64'd1;
    e    = (op >> fw) & emax;
    fr   = op & ((64'd1 << fw) - 64'd1);
    inv  = 1'b0;
    fl   = 1'b0;
    if (e == emax && fr != 0) begin
      inv = ((fr >> (fw - 1)) & 64'd1) == 0;
      if (dn) r = (emax << fw) | (64'd1 << (fw - 1));
      else    r = op | (64'd1 << (fw - 1));
    end else begin
      fl = ftz && e == 0 && fr != 0;
      ne = (e == 0) ? emax - 64'd1 : (~e & emax);
      r  = (s << (ew + fw)) | (ne << fw);
    end
  endfunction

  task automatic compare(input logic [63:0] er, input logic ei, input logic ef, input string tag);
    checks++;
    if (result_o !== er || invalid_o !== ei || flushed_o !== ef) begin
      errors++;
      $display("FAIL %s: actual r=%h inv=%b fl=%b expected r=%h inv=%b fl=%b",
               tag, result_o, invalid_o, flushed_o, er, ei, ef);
    end
  endtask

  // Called at a falling edge: drive, let one rising edge pass, check at next falling edge.
  task automatic vec(input logic [63:0] op, input logic [1:0] f, input logic ftz,
                     input logic dn, input string tag);
    logic [63:0] er;
    logic ei, ef;
    operand_i = op; fmt_i = f; ftz_i = ftz; dn_mode_i = dn;
    model(op, f, ftz, dn, er, ei, ef);
    @(negedge clk);
    compare(er, ei, ef, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare(64'd0, 1'b0, 1'b0, "R9 reset");
    rst = 1'b0;
    // R2 zero-exponent path
    vec(64'h0000, 2'd0, 0, 0, "R2 half +0");
    vec(64'h80000000, 2'd1, 0, 0, "R2 single -0");
    vec(64'h0, 2'd2, 0, 0, "R2 double +0");
    vec(64'h000F, 2'd0, 0, 0, "R2 half subnormal");
    // R3 complement path
    vec(64'h3C00, 2'd0, 0, 0, "R3 half 1.0");
    vec(64'h7C00, 2'd0, 0, 0, "R3 half inf");
    vec(64'h40490FDB, 2'd1, 0, 0, "R3 single pi");
    vec(64'hC000000000000000, 2'd2, 0, 0, "R3 double -2");
    vec(64'hFFF0000000000000, 2'd2, 0, 0, "R3 double -inf");
    // R4 / R5 NaNs
    vec(64'h7D00, 2'd0, 0, 0, "R4 half sNaN");
    vec(64'h7E01, 2'd0, 0, 0, "R4 half qNaN");
    vec(64'hFF800001, 2'd1, 0, 1, "R5 single sNaN dn");
    vec(64'h7FC12345, 2'd1, 0, 0, "R5 single qNaN kept");
    vec(64'hFFF8000000000001, 2'd2, 0, 1, "R5 double qNaN dn");
    vec(64'h7FF0000000000001, 2'd2, 0, 0, "R5 double sNaN quiet");
    vec(64'hFE01, 2'd0, 1, 1, "R5 half NaN dn");
    // R6 flush
    vec(64'h8001, 2'd0, 1, 0, "R6 half denorm ftz");
    vec(64'h8001, 2'd0, 0, 0, "R6 half denorm noftz");
    vec(64'h000FFFFFFFFFFFFF, 2'd2, 1, 0, "R6 double denorm ftz");
    vec(64'h00000000, 2'd1, 1, 0, "R6 zero no flag");
    // R7 format 3 as double
    vec(64'h3FF0000000000000, 2'd3, 0, 0, "R7 fmt3");
    vec(64'h0000000000000001, 2'd3, 1, 0, "R7 fmt3 denorm");
    // R8 upper bits ignored
    vec(64'hDEADBEEF12343C00, 2'd0, 0, 0, "R8 half junk");
    vec(64'hFFFFFFFF00000000, 2'd1, 0, 0, "R8 single junk");
    vec(64'hFFFFFFFF7F800001, 2'd1, 0, 0, "R8 single NaN junk");
    // R9 mid-run reset
    operand_i = 64'h3C00; fmt_i = 2'd0; rst = 1'b1;
    @(negedge clk);
    compare(64'd0, 1'b0, 1'b0, "R9 mid reset");
    rst = 1'b0;
    // R1 random mix
    for (int i = 0; i < 400; i++) begin
      logic [63:0] op;
      op = {$urandom, $urandom};
      if (i % 4 == 0) op[62:52] = '0;
      if (i % 5 == 0) op[30:23] = '1;
      if (i % 7 == 0) op[14:10] = '0;
      vec(op, 2'($urandom), 1'($urandom), 1'($urandom), "R1 random");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule